// File: doc/BRIEF.md
# Transmit Phase Compensation Buffer

This block carries parallel transmit words from a fabric-side clock domain into the transceiver-side parallel clock domain. Both clocks run at the same nominal rate but their phase relation is unknown, and they may come from separate clock sources. In phase compensation mode the block works as a four-entry asynchronous FIFO. Its read and write pointers are Gray coded and pass through two-flop synchronizers into the opposite domain. Each side gets its own full or empty flag and its own sticky error flag.

A static mode input selects a second behaviour, registered mode. Here the FIFO is bypassed and the incoming word is captured by a single register clocked by the read clock, so latency is exactly one read-clock cycle. The mode may only change while both domains are held in reset. Resets are synchronous and active high, one per domain. After reset the read-side output word reads zero until the first valid word arrives.

Top module: `tpc_fifo`

## Requirements
- R1: While either reset is held and in the cycle after its release, `rd_data` is 0, `rd_valid` is 0, `empty` is 1, `full` is 0 and both error flags are 0.
- R2: In phase compensation mode (`mode`=0), the words accepted while `full`=0 leave on `rd_data` in the order they were written, with no loss or repetition; pointers change by one Gray bit per step.
- R3: `full` rises at the write-clock edge that accepts the fourth unread word, and a write presented while `full`=1 is discarded.
- R4: A read with `rd_en`=1 and `empty`=0 presents the oldest word on `rd_data` with `rd_valid`=1 one read-clock edge later; `empty` rises at the edge that takes the last stored word and falls within three read-clock edges after a write.
- R5: `ovf_err` (write domain) sets when `wr_en`=1 while `full`=1 in phase compensation mode.
- R6: `unf_err` (read domain) sets when `rd_en`=1 while `empty`=1 in phase compensation mode; `rd_valid` stays 0 for that request.
- R7: In registered mode (`mode`=1), `wr_en`/`wr_data` are sampled by `rd_clk`; one `rd_clk` edge later `rd_valid` equals the sampled `wr_en`, and `rd_data` takes `wr_data` when it was 1 and otherwise holds.
- R8: In registered mode `rd_data` stays 0 after reset until the first sampled `wr_en`=1.
- R9: In registered mode the FIFO is unused: `rd_en` is ignored, `empty` stays 1, `full` stays 0 and neither error flag sets.
- R10: Both error flags are sticky and clear only on their own domain's reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Fabric-side write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| rd_clk | input | 1 | Transceiver-side read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| mode | input | 1 | 0 = phase compensation FIFO, 1 = registered bypass |
| wr_en | input | 1 | Write request / bypass word valid |
| wr_data | input | DATA_W | Word to transmit |
| full | output | 1 | FIFO holds four unread words (write domain) |
| ovf_err | output | 1 | Sticky overflow flag (write domain) |
| rd_en | input | 1 | Read request (phase compensation mode) |
| rd_data | output | DATA_W | Registered output word |
| rd_valid | output | 1 | `rd_data` updated by a read or bypass capture |
| empty | output | 1 | No word visible to the read side |
| unf_err | output | 1 | Sticky underflow flag (read domain) |

## Verification
In registered mode the result is due one `rd_clk` edge after the input is driven, so the bench drives on a falling `rd_clk` edge and compares at the next falling edge. In FIFO mode `full`, `ovf_err`, `unf_err` and the read data all follow their own domain's next rising edge and are checked at the falling edge after it. Only the cross-domain fall of `empty` takes up to three read edges, so the directed test waits five read cycles before looking at it. The random streaming phase issues requests only from flags sampled between edges and matches every `rd_valid` word against a bench scoreboard in write order.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic {
    TPC_PHASE  = 1'b0,
    TPC_BYPASS = 1'b1
  } tpc_mode_e;

  // pointer width: address bits plus one wrap bit
  function automatic int tpc_ptr_w(input int depth);
    return $clog2(depth) + 1;
  endfunction
endpackage

// File: rtl/tpc_sync2.sv
module tpc_sync2 #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/tpc_mem.sv
module tpc_mem #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/tpc_wr_ctrl.sv
module tpc_wr_ctrl #(
  parameter int PW  = 3,
  localparam int AW = PW - 1
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          req,
  input  logic [PW-1:0] rgray_s,
  output logic          fire,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full,
  output logic          ovf_err
);
  localparam logic [PW-1:0] FLIP = PW'(3) << (PW - 2);

  logic [PW-1:0] wbin, wbin_nx, wgray_nx;

  assign fire     = req & ~full;
  assign wbin_nx  = wbin + PW'(fire);
  assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wbin    <= '0;
      wgray   <= '0;
      full    <= 1'b0;
      ovf_err <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      full  <= (wgray_nx == (rgray_s ^ FLIP));
      if (req && full) ovf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/tpc_rd_ctrl.sv
module tpc_rd_ctrl #(
  parameter int PW  = 3,
  localparam int AW = PW - 1
) (
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          req,
  input  logic [PW-1:0] wgray_s,
  output logic          fire,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty,
  output logic          unf_err
);
  logic [PW-1:0] rbin, rbin_nx, rgray_nx;

  assign fire     = req & ~empty;
  assign rbin_nx  = rbin + PW'(fire);
  assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rbin    <= '0;
      rgray   <= '0;
      empty   <= 1'b1;
      unf_err <= 1'b0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rgray_nx;
      empty <= (rgray_nx == wgray_s);
      if (req && empty) unf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/tpc_fifo.sv
module tpc_fifo
  import tpc_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 4,
  localparam int PW    = tpc_ptr_w(DEPTH),
  localparam int AW    = PW - 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic              ovf_err,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty,
  output logic              unf_err
);
  logic              bypass;
  logic              wr_fire, rd_fire;
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [DATA_W-1:0] mem_rdata;

  assign bypass = (mode == TPC_BYPASS);

  tpc_wr_ctrl #(.PW(PW)) u_wr (
    .wr_clk (wr_clk),
    .wr_rst (wr_rst),
    .req    (wr_en & ~bypass),
    .rgray_s(rgray_s),
    .fire   (wr_fire),
    .waddr  (waddr),
    .wgray  (wgray),
    .full   (full),
    .ovf_err(ovf_err)
  );

  tpc_rd_ctrl #(.PW(PW)) u_rd (
    .rd_clk (rd_clk),
    .rd_rst (rd_rst),
    .req    (rd_en & ~bypass),
    .wgray_s(wgray_s),
    .fire   (rd_fire),
    .raddr  (raddr),
    .rgray  (rgray),
    .empty  (empty),
    .unf_err(unf_err)
  );

  tpc_sync2 #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
  );

  tpc_sync2 #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
  );

  tpc_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .wr_clk(wr_clk),
    .we    (wr_fire),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (mem_rdata)
  );

  // output register shared by both modes
  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else if (bypass) begin
      rd_valid <= wr_en;
      if (wr_en) rd_data <= wr_data;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= mem_rdata;
    end
  end
endmodule

// File: rtl/tpc_fifo_chk.sv
module tpc_fifo_chk #(
  parameter int DATA_W = 10,
  parameter int PW     = 3
) (
  input logic              wr_clk,
  input logic              wr_rst,
  input logic              rd_clk,
  input logic              rd_rst,
  input logic              mode,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              full,
  input logic              ovf_err,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              empty,
  input logic              unf_err,
  input logic [PW-1:0]     wgray,
  input logic [PW-1:0]     rgray
);
  // R2
  wgray_step_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R2
  rgray_step_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $countones(rgray ^ $past(rgray)) <= 1);

  // R3
  no_write_past_full_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (full && wr_en && !mode) |=> $stable(wgray));

  // R4
  valid_from_read_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (!mode && rd_valid) |-> $past(rd_en && !empty));

  // R10
  ovf_sticky_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    ovf_err |=> ovf_err);

  // R10
  unf_sticky_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    unf_err |=> unf_err);

  // R7
  bypass_latency_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (mode && wr_en) |=> (rd_valid && rd_data == $past(wr_data)));

  // R9
  bypass_idle_chk: assert property (@(posedge rd_clk) disable iff (rd_rst || wr_rst)
    mode |-> (empty && !full && !unf_err && !ovf_err));
endmodule

bind tpc_fifo tpc_fifo_chk #(.DATA_W(DATA_W), .PW(PW)) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
  .mode(mode), .wr_en(wr_en), .wr_data(wr_data), .full(full),
  .ovf_err(ovf_err), .rd_en(rd_en), .rd_data(rd_data),
  .rd_valid(rd_valid), .empty(empty), .unf_err(unf_err),
  .wgray(wgray), .rgray(rgray)
);

// File: tb/sim_tpc_fifo.sv
module sim_tpc_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int RD_SKEW    = 3;
  localparam int DW         = 10;
  localparam int NSTREAM    = 160;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst = 1, rd_rst = 1;
  logic mode = 0, wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic full, ovf_err, rd_valid, empty, unf_err;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] sb [0:255];

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  initial begin
    #RD_SKEW;
    forever #(CLK_PERIOD/2) rd_clk = ~rd_clk;
  end

  tpc_fifo #(.DATA_W(DW), .DEPTH(4)) u0 (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .mode(mode), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .ovf_err(ovf_err), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .empty(empty), .unf_err(unf_err)
  );

  function automatic logic [DW-1:0] rnd_word();
    return DW'($urandom);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    wr_en = 0; rd_en = 0;
    @(negedge wr_clk); wr_rst = 1;
    @(negedge rd_clk); rd_rst = 1;
    mode = m;
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk); wr_rst = 0;
    @(negedge rd_clk); rd_rst = 0;
    @(negedge rd_clk);
  endtask

  task automatic stream_test();
    int wc = 0, ri = 0, rc = 0;
    fork
      begin
        while (wc < NSTREAM) begin
          @(negedge wr_clk);
          if (!full && ($urandom % 4 != 0)) begin
            wr_en = 1; wr_data = rnd_word(); sb[wc[7:0]] = wr_data; wc++;
          end else wr_en = 0;
        end
        @(negedge wr_clk); wr_en = 0;
      end
      begin
        while (rc < NSTREAM) begin
          @(negedge rd_clk);
          if (rd_valid) begin
            chk("R2 stream order", rd_data, sb[rc[7:0]]); rc++;
          end
          if (ri < NSTREAM && !empty && ($urandom % 3 != 0)) begin
            rd_en = 1; ri++;
          end else rd_en = 0;
        end
        rd_en = 0;
      end
    join
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d [0:4];
    logic [DW-1:0] held, pd;
    logic pe;
    void'($urandom(32'd2024));

    // R1: reset state, FIFO mode
    do_reset(1'b0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 errors", {ovf_err, unf_err}, 0);

    // R3 / R5: fill four, then one more
    for (int i = 0; i < 5; i++) d[i] = rnd_word();
    for (int i = 0; i < 4; i++) begin
      @(negedge wr_clk); wr_en = 1; wr_data = d[i];
      if (i < 3) chk("R3 full before fourth", full, 0);
    end
    @(negedge wr_clk);
    chk("R3 full after fourth", full, 1);
    chk("R5 no overflow yet", ovf_err, 0);
    wr_data = d[4];
    @(negedge wr_clk); wr_en = 0;
    chk("R5 overflow set", ovf_err, 1);
    chk("R3 full holds", full, 1);

    // R4: empty clears within three read edges
    repeat (5) @(negedge rd_clk);
    chk("R4 empty cleared", empty, 0);
    rd_en = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge rd_clk);
      chk("R4 rd_valid", rd_valid, 1);
      chk("R2 directed order", rd_data, d[i]);
      if (i == 3) rd_en = 0;
    end
    chk("R4 empty after last", empty, 1);
    @(negedge rd_clk);
    chk("R4 valid drops", rd_valid, 0);
    chk("R6 no underflow yet", unf_err, 0);

    // R6: read while empty
    rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
    chk("R6 underflow set", unf_err, 1);
    chk("R6 no valid", rd_valid, 0);
    chk("R3 dropped word not stored", empty, 1);

    // R2 stream, then R10 stickiness
    stream_test();
    repeat (3) @(negedge wr_clk);
    chk("R10 ovf sticky", ovf_err, 1);
    chk("R10 unf sticky", unf_err, 1);
    do_reset(1'b0);
    chk("R10 cleared by reset", {ovf_err, unf_err}, 0);

    // registered mode
    do_reset(1'b1);
    chk("R1 rd_data bypass", rd_data, 0);
    repeat (3) begin
      @(negedge rd_clk); rd_en = 1;
    end
    @(negedge rd_clk); rd_en = 0;
    chk("R8 zero before first word", rd_data, 0);
    chk("R8 no valid", rd_valid, 0);
    held = '0; pe = 0; pd = '0;
    for (int k = 0; k < 60; k++) begin
      @(negedge rd_clk);
      if (k > 0) begin
        chk("R7 valid follows wr_en", rd_valid, pe);
        if (pe) held = pd;
        chk("R7 data", rd_data, held);
      end
      pe = ($urandom % 2 == 1);
      pd = rnd_word();
      wr_en = pe; wr_data = pd;
      rd_en = ($urandom % 2 == 1);
    end
    @(negedge rd_clk);
    wr_en = 0; rd_en = 0;
    chk("R7 last", rd_valid, pe);
    chk("R9 empty held", empty, 1);
    chk("R9 full low", full, 0);
    chk("R9 no errors", {ovf_err, unf_err}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule